// File: doc/BRIEF.md
# Dual-Source 16-Bit Up-Counter

This block is a 16-bit up-counter that advances from one of two sources. In interval mode it adds one on every machine-cycle tick, so it counts elapsed machine cycles. In event mode it watches an external count pin. It samples that pin on each machine-cycle tick and adds one when a sample of 1 is followed by a sample of 0. A falling edge therefore needs two ticks to be seen, which caps the event rate at half the tick rate.

Three control bits govern counting: a run enable, a source select and a gate enable. When the gate is enabled, an increment also needs the external gate pin to be high at the tick that would cause it. Software reaches the control bits, the two count bytes and the overflow flag through a byte-wide write port. The count value and the overflow flag are presented as outputs. Both pins are expected to be synchronous to `clk` already.

The edge watcher is a two-state machine clocked by `clk` that only moves on ticks:
- `PIN_WAS_LO` is the reset state and means the last sample was 0. It moves to `PIN_WAS_HI` on a tick that samples 1.
- `PIN_WAS_HI` means the last sample was 1. It moves back to `PIN_WAS_LO` on a tick that samples 0, and that transition is the event.

Top module: `dual_src_timer`

## Requirements
- R1: After reset the count is 0000h, the overflow flag is 0 and all three control bits are 0, so ticks do not change the count until software writes the control register.
- R2: With control value 001b (bit0 run=1, bit1 select=0 for interval, bit2 gate=0), the count goes up by one at every `clk` edge where `mc_tick` is 1. It does not change at edges where `mc_tick` is 0.
- R3: With run=0, the count holds whatever the tick, the count pin and the gate pin do.
- R4: With select=1 (event mode) and run=1, the count goes up by one at a tick edge whose `ev_pin` sample is 0 when the previous tick's sample was 1.
- R5: In event mode, `ev_pin` values between ticks are not seen. A pin held at one level across ticks gives no increment, and a pulse that starts and ends between two ticks gives no increment.
- R6: With gate=1, an increment happens only if `gate_pin` is 1 in the same cycle as the qualifying tick. With gate=0, `gate_pin` has no effect.
- R7: An increment from FFFFh gives 0000h and sets the overflow flag. The flag stays set until a write to address 1, which loads the flag from `wr_data[0]`.
- R8: A write to address 0 loads the control bits from `wr_data[2:0]`, taking effect the next cycle. A write to address 2 loads the low count byte and a write to address 3 loads the high count byte. A count-byte write overrides an increment in the same cycle, but an increment from FFFFh in that cycle still sets the flag.
- R9: If an overflow and a flag write happen in the same cycle, the flag ends up set.
- R10: Reset returns the edge watcher to `PIN_WAS_LO`, so a 0 sample on the first tick after reset does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_tick | input | 1 | One-cycle pulse per machine cycle |
| ev_pin | input | 1 | External event input, sampled on ticks |
| gate_pin | input | 1 | External qualifier used when the gate bit is set |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 flag, 2 count low, 3 count high |
| wr_data | input | 8 | Write data |
| count | output | 16 | Current count value |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench targets a pin pulse that rises and falls between two ticks. A design that watched the pin every clock instead of every tick would count that pulse. It also checks a low level on the first tick after reset, which an edge watcher that powered up "high" would count. The wrap from FFFFh is driven by preloading both count bytes. A flag write is then made to land in the same cycle as an overflow, and a design that let the write win would lose the event. A count-byte write is placed on a tick, where an adder given priority would leave the count one higher than the written value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Edge watcher states: level seen at the most recent tick
    typedef enum logic {
        PIN_WAS_LO = 1'b0,
        PIN_WAS_HI = 1'b1
    } edge_st_t;

    // Control bits, packed so that bit0=run, bit1=select, bit2=gate
    typedef struct packed {
        logic gate;
        logic sel;
        logic run;
    } ctl_t;

    localparam int unsigned ADR_CTL  = 0;
    localparam int unsigned ADR_FLAG = 1;
    localparam int unsigned ADR_CNT0 = 2;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3,
    localparam int NB    = CNT_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [2:0]        wr_lsb,
    output ctl_t              ctl,
    output logic              flag_we,
    output logic              flag_wd,
    output logic [NB-1:0]     byte_we
);

    logic ctl_we;

    assign ctl_we  = wr_en && (wr_addr == ADDR_W'(ADR_CTL));
    assign flag_we = wr_en && (wr_addr == ADDR_W'(ADR_FLAG));
    assign flag_wd = wr_lsb[0];

    // one write strobe per count byte
    for (genvar b = 0; b < NB; b++) begin : g_byte_sel
        assign byte_we[b] = wr_en && (wr_addr == ADDR_W'(ADR_CNT0 + b));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (ctl_we) begin
            ctl <= ctl_t'(wr_lsb);
        end
    end

    // R8: control bits change only through their own address
    a_r8_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(ctl));

    // R8: a control write lands the next cycle
    a_r8_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (ctl == ctl_t'($past(wr_lsb))));

endmodule

// File: rtl/tmr_edge.sv
module tmr_edge
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic fall
);

    edge_st_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PIN_WAS_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: only a tick moves the machine
    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                PIN_WAS_LO: if (pin)  state_d = PIN_WAS_HI;
                PIN_WAS_HI: if (!pin) state_d = PIN_WAS_LO;
                default:              state_d = PIN_WAS_LO;
            endcase
        end
    end

    // output: event on the HI->LO transition
    always_comb begin
        fall = 1'b0;
        unique case (state_q)
            PIN_WAS_HI: fall = tick && !pin;
            PIN_WAS_LO: fall = 1'b0;
            default:    fall = 1'b0;
        endcase
    end

    // R4: a high sample on a tick arms the watcher
    a_r4_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pin) |=> (state_q == PIN_WAS_HI));

    // R5: two events in a row are impossible
    a_r5_no_double: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

    // R5: nothing is seen between ticks
    a_r5_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state_q));

    // R10: right after reset the watcher is disarmed
    a_r10_reset_lo: assert property (@(posedge clk)
        !rst_n |=> (state_q == PIN_WAS_LO));

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int NB   = CNT_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_t             ctl,
    input  logic             tick,
    input  logic             fall,
    input  logic             gate_pin,
    input  logic [NB-1:0]    byte_we,
    input  logic [7:0]       wr_data,
    input  logic             flag_we,
    input  logic             flag_wd,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q
);

    logic             src, allow, inc, wrap;
    logic [CNT_W-1:0] cnt_d;

    assign src   = ctl.sel ? fall : tick;
    assign allow = !ctl.gate || gate_pin;
    assign inc   = ctl.run && allow && src;
    assign wrap  = inc && (cnt_q == '1);

    always_comb begin
        cnt_d = inc ? cnt_q + CNT_W'(1) : cnt_q;
        for (int b = 0; b < NB; b++) begin
            if (byte_we[b]) cnt_d[b*8 +: 8] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (wrap)         ovf_q <= 1'b1;
            else if (flag_we) ovf_q <= flag_wd;
        end
    end

    // R2: one step per accepted increment
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && byte_we == '0) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R3: stopped counter holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.run && byte_we == '0) |=> $stable(cnt_q));

    // R6: closed gate blocks counting
    a_r6_gate_block: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.gate && !gate_pin && byte_we == '0) |=> $stable(cnt_q));

    // R7: wrap sets the flag
    a_r7_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_q);

    // R7: the flag is sticky without a flag write
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !flag_we) |=> ovf_q);

    // R8: a low-byte write wins over an increment
    a_r8_low_write: assert property (@(posedge clk) disable iff (!rst_n)
        byte_we[0] |=> (cnt_q[7:0] == $past(wr_data)));

endmodule

// File: rtl/dual_src_timer.sv
module dual_src_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              ev_pin,
    input  logic              gate_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              ovf
);

    localparam int NB = CNT_W / 8;

    ctl_t          ctl;
    logic          flag_we, flag_wd, fall;
    logic [NB-1:0] byte_we;

    tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_lsb  (wr_data[2:0]),
        .ctl     (ctl),
        .flag_we (flag_we),
        .flag_wd (flag_wd),
        .byte_we (byte_we)
    );

    tmr_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (mc_tick),
        .pin   (ev_pin),
        .fall  (fall)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .tick     (mc_tick),
        .fall     (fall),
        .gate_pin (gate_pin),
        .byte_we  (byte_we),
        .wr_data  (wr_data),
        .flag_we  (flag_we),
        .flag_wd  (flag_wd),
        .cnt_q    (count),
        .ovf_q    (ovf)
    );

    // R1: reset leaves a cleared count and flag
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !ovf));

endmodule

// File: tb/test_dual_src_timer.sv
module test_dual_src_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mc_tick = 1'b0, ev_pin = 1'b0, gate_pin = 1'b0, wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] count;
    logic        ovf;

    int n_run = 0, n_fail = 0;

    // bench model of the requirements
    logic [15:0] m_cnt = '0;
    logic        m_ovf = 1'b0;
    logic [2:0]  m_ctl = '0;
    logic        m_hi  = 1'b0;

    always #4 clk = ~clk;

    dual_src_timer i_dual_src_timer (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .ev_pin(ev_pin),
        .gate_pin(gate_pin), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .ovf(ovf)
    );

    function automatic logic will_inc(input logic [2:0] c, input logic hi,
                                      input logic tk, input logic pn, input logic gp);
        logic s;
        s = c[1] ? (tk && hi && !pn) : tk;
        return c[0] && (!c[2] || gp) && s;
    endfunction

    task automatic check(input string tag);
        n_run++;
        if (count !== m_cnt || ovf !== m_ovf) begin
            n_fail++;
            $display("FAIL %s: count=%h ovf=%b expected count=%h ovf=%b",
                     tag, count, ovf, m_cnt, m_ovf);
        end
    endtask

    task automatic cyc(input logic tk, input logic pn, input logic gp,
                       input logic we, input logic [2:0] ad, input logic [7:0] dt,
                       input string tag, input logic do_chk = 1'b1);
        logic [15:0] n_cnt;
        logic        n_ovf, n_hi, inc;
        logic [2:0]  n_ctl;
        @(negedge clk);
        mc_tick = tk; ev_pin = pn; gate_pin = gp;
        wr_en = we; wr_addr = ad; wr_data = dt;
        inc   = will_inc(m_ctl, m_hi, tk, pn, gp);
        n_cnt = inc ? m_cnt + 16'd1 : m_cnt;
        n_ovf = m_ovf; n_ctl = m_ctl;
        n_hi  = tk ? pn : m_hi;
        if (we) begin
            case (ad)
                3'd0: n_ctl = dt[2:0];
                3'd1: n_ovf = dt[0];
                3'd2: n_cnt[7:0] = dt;
                3'd3: n_cnt[15:8] = dt;
                default: ;
            endcase
        end
        if (inc && m_cnt == 16'hFFFF) n_ovf = 1'b1;
        @(posedge clk);
        m_cnt = n_cnt; m_ovf = n_ovf; m_ctl = n_ctl; m_hi = n_hi;
        #2;
        if (do_chk) check(tag);
    endtask

    task automatic wr(input logic [2:0] ad, input logic [7:0] dt, input string tag);
        cyc(1'b0, ev_pin, 1'b0, 1'b1, ad, dt, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; mc_tick = 0; wr_en = 0;
        @(posedge clk); @(posedge clk);
        #1 rst_n = 1'b1;
        m_cnt = '0; m_ovf = 0; m_ctl = '0; m_hi = 0;
        #1 check("R1 reset state");
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5EED));
        do_reset();
        // R1: ticks before any control write do nothing
        repeat (3) cyc(1, 1, 1, 0, 0, 0, "R1 idle after reset");
        cyc(1, 0, 1, 0, 0, 0, "R1 idle after reset");

        // R2: interval mode, ticks with gaps
        wr(0, 8'h01, "R8 control write");
        for (int i = 0; i < 6; i++) begin
            cyc(1, 0, 0, 0, 0, 0, "R2 tick step");
            cyc(0, 0, 0, 0, 0, 0, "R2 no tick hold");
        end

        // R3: stopped
        wr(0, 8'h00, "R8 control write");
        repeat (4) cyc(1, 1, 1, 0, 0, 0, "R3 run off hold");
        cyc(1, 0, 1, 0, 0, 0, "R3 run off hold");

        // R4/R5: event mode
        wr(0, 8'h03, "R8 control write");
        cyc(1, 1, 0, 0, 0, 0, "R4 arm high");
        cyc(1, 0, 0, 0, 0, 0, "R4 fall counted");
        repeat (3) cyc(1, 0, 0, 0, 0, 0, "R5 steady low");
        repeat (3) cyc(1, 1, 0, 0, 0, 0, "R5 steady high");
        cyc(1, 0, 0, 0, 0, 0, "R4 fall counted");
        cyc(0, 1, 0, 0, 0, 0, "R5 pulse between ticks");
        cyc(0, 1, 0, 0, 0, 0, "R5 pulse between ticks");
        cyc(0, 0, 0, 0, 0, 0, "R5 pulse between ticks");
        cyc(1, 0, 0, 0, 0, 0, "R5 pulse between ticks unseen");

        // R10: reset disarms the watcher
        cyc(1, 1, 0, 0, 0, 0, "R10 arm before reset");
        do_reset();
        wr(0, 8'h03, "R8 control write");
        cyc(1, 0, 0, 0, 0, 0, "R10 first low not counted");
        cyc(1, 1, 0, 0, 0, 0, "R10 arm");
        cyc(1, 0, 0, 0, 0, 0, "R10 fall counted");

        // R6: gate
        wr(0, 8'h05, "R8 control write");
        repeat (3) cyc(1, 0, 0, 0, 0, 0, "R6 gate closed");
        repeat (3) cyc(1, 0, 1, 0, 0, 0, "R6 gate open");
        wr(0, 8'h07, "R8 control write");
        cyc(1, 1, 1, 0, 0, 0, "R6 event arm");
        cyc(1, 0, 0, 0, 0, 0, "R6 event gate closed");
        wr(0, 8'h01, "R8 control write");
        repeat (3) cyc(1, 0, 0, 0, 0, 0, "R6 gate ignored");

        // R7/R8: wrap
        wr(2, 8'hFE, "R8 low byte write");
        wr(3, 8'hFF, "R8 high byte write");
        cyc(1, 0, 0, 0, 0, 0, "R7 to FFFF");
        cyc(1, 0, 0, 0, 0, 0, "R7 wrap sets flag");
        repeat (3) cyc(1, 0, 0, 0, 0, 0, "R7 flag sticky");
        wr(1, 8'h00, "R7 flag cleared");
        cyc(1, 0, 0, 1, 2, 8'h40, "R8 write beats increment");
        wr(3, 8'hFF, "R8 high byte write");
        wr(2, 8'hFF, "R8 low byte write");
        cyc(1, 0, 0, 1, 2, 8'h12, "R8 write at wrap still flags");
        wr(1, 8'h00, "R7 flag cleared");
        wr(2, 8'hFF, "R8 low byte write");
        wr(3, 8'hFF, "R8 high byte write");
        cyc(1, 0, 0, 1, 1, 8'h00, "R9 set beats clear");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic tk, pn, gp, we;
            logic [2:0] ad;
            logic [7:0] dt;
            tk = ($urandom % 3) != 0;
            pn = $urandom % 2;
            gp = ($urandom % 4) != 0;
            we = ($urandom % 16) == 0;
            ad = 3'($urandom % 4);
            dt = 8'($urandom);
            if (we && ad == 3'd3 && ($urandom % 2)) dt = 8'hFF;
            cyc(tk, pn, gp, we, ad, dt, "R2,R4,R6,R7 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule